// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block sits next to a processor core and arbitrates among up to 256 interrupt vectors. It holds three bit maps indexed by vector number: one of vectors requested, one of vectors whose handlers are running, and one recording whether each request arrived as level-triggered. Incoming vectors arrive on a set port with a trigger flag. A task priority value written by software, together with the highest running vector, forms a processor priority. Only requests from a higher priority class get through to the core.

The core sees a single request line. It takes a vector with a one-cycle acknowledge handshake that returns the winning vector, a spurious code, or nothing. It signals completion of a handler with an end-of-interrupt strobe. When a completed vector was level-triggered, the block announces that vector on a broadcast output so that upstream sources can re-sample their lines. A configuration register supplies the spurious code, a global enable and a flag that suppresses that broadcast.

Top module: `vec_prio_ctrl`

## Requirements
- R1: Reset clears all three bit maps and the task priority. It loads the configuration register with 0x00FF, which leaves the enable bit clear. After reset `irq_out` is 0 and `proc_pri` is 0.
- R2: A set with `set_level`=1 marks the vector requested and level-triggered. A set with `set_level`=0 marks it requested and edge-triggered, and clears any earlier level mark for that vector.
- R3: The request with the largest vector number wins. An acknowledge returns it, and this holds across 32-bit word boundaries (0x20 beats 0x1F).
- R4: The priority class of a vector is bits 7:4. `proc_pri` equals the task priority when the task priority class is greater than or equal to the class of the highest running vector. Otherwise it equals that class followed by four zero bits. No running vector counts as class 0.
- R5: While configuration bit 8 (enable) is 0, `irq_out` is 0 and an acknowledge returns no vector.
- R6: A request is blocked when `proc_pri` is nonzero and the class of the top request is less than or equal to the class of `proc_pri`. While it is blocked, `irq_out` is 0. An acknowledge in that state returns configuration bits 7:0 with `ack_rsp_hit`=1 and changes no bit map.
- R7: Every acknowledge gets `ack_rsp_valid` on the next cycle. With no request pending, `ack_rsp_hit` is 0.
- R8: An acknowledge that is granted moves the vector from requested to running. This raises `proc_pri` and drops `irq_out` when nothing else is deliverable.
- R9: An end-of-interrupt clears the highest running vector. If nothing is running, it does nothing. If the cleared vector was level-triggered, `eoi_bcast_valid` pulses on the next cycle with the vector on `eoi_bcast_vec`.
- R10: While configuration bit 12 (broadcast suppress) is 1, no broadcast is emitted.
- R11: A configuration write stores only bits 12 and 8:0. All other bits read back as 0 on `spur_cfg`.
- R12: `irq_out` is combinational from the stored state. It reflects any change on the cycle after the edge that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_valid | input | 1 | Request a vector this cycle |
| set_vec | input | 8 | Vector to request |
| set_level | input | 1 | 1 = level-triggered, 0 = edge |
| task_pri_we | input | 1 | Write task priority |
| task_pri_wdata | input | 8 | New task priority |
| spur_cfg_we | input | 1 | Write configuration |
| spur_cfg_wdata | input | 16 | New configuration (bit 12 suppress, bit 8 enable, 7:0 spurious code) |
| ack_req | input | 1 | Core acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_out | output | 1 | Deliverable interrupt pending |
| ack_rsp_valid | output | 1 | Acknowledge response present |
| ack_rsp_hit | output | 1 | Response carries a vector (real or spurious) |
| ack_rsp_vec | output | 8 | Returned vector |
| eoi_bcast_valid | output | 1 | Level-triggered completion broadcast |
| eoi_bcast_vec | output | 8 | Vector being broadcast |
| proc_pri | output | 8 | Current processor priority |
| spur_cfg | output | 16 | Stored configuration |

## Verification
A wrong bit in the running map shows on `proc_pri` in the cycle after the edge that corrupted it. It also shows in which vector the next end-of-interrupt clears, and that is seen one cycle later on the broadcast port. A wrong requested bit or class comparison changes `irq_out` immediately. It shows on the next acknowledge as the wrong vector or a spurious code. A stale level mark only appears when that vector completes, as a missing or extra broadcast. For that reason the stimulus retriggers a vector with both edge and level before completing it.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
    localparam int VEC_W       = 8;
    localparam int NUM_VEC     = 1 << VEC_W;
    localparam int CLS_W       = 4;
    localparam int CFG_W       = 16;
    localparam int CFG_EN_BIT  = 8;
    localparam int CFG_SUP_BIT = 12;
    localparam logic [CFG_W-1:0] CFG_KEEP = 16'h11FF;
    localparam logic [CFG_W-1:0] CFG_RST  = 16'h00FF;

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [CLS_W-1:0] cls_t;

    typedef struct packed {
        logic valid;
        logic hit;
        vec_t vec;
    } ack_rsp_t;

    function automatic cls_t cls_of(vec_t v);
        return v[VEC_W-1 -: CLS_W];
    endfunction

    function automatic vec_t ppr_of(vec_t tpr, logic run_any, vec_t run_top);
        cls_t rc;
        rc = run_any ? cls_of(run_top) : '0;
        if (cls_of(tpr) >= rc) return tpr;
        return {rc, {(VEC_W-CLS_W){1'b0}}};
    endfunction
endpackage

// File: rtl/vpc_prio_scan.sv
module vpc_prio_scan #(
    parameter int N = 256,
    parameter int W = 32
) (
    input  logic [N-1:0]         bits,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int NW = N / W;
    localparam int LW = $clog2(W);
    localparam int IW = $clog2(N);

    function automatic logic [LW-1:0] top_in_word(logic [W-1:0] x);
        logic [LW-1:0] r;
        r = '0;
        for (int j = 0; j < W; j++) if (x[j]) r = LW'(j);
        return r;
    endfunction

    logic [NW-1:0]         w_any;
    logic [NW-1:0][LW-1:0] w_idx;

    for (genvar g = 0; g < NW; g++) begin : g_word
        assign w_any[g] = |bits[g*W +: W];
        assign w_idx[g] = top_in_word(bits[g*W +: W]);
    end

    always_comb begin
        found = |w_any;
        idx   = '0;
        for (int w = 0; w < NW; w++)
            if (w_any[w]) idx = IW'(w * W) + IW'(w_idx[w]);
    end
endmodule

// File: rtl/vpc_vec_regs.sv
module vpc_vec_regs
    import vpc_pkg::*;
#(
    parameter int N = NUM_VEC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_valid,
    input  vec_t         set_vec,
    input  logic         set_level,
    input  logic         ack_take,
    input  vec_t         ack_vec,
    input  logic         eoi_take,
    input  vec_t         eoi_vec,
    output logic [N-1:0] irr,
    output logic [N-1:0] isr,
    output logic [N-1:0] tmr
);
    logic [N-1:0] set_mask, ack_mask, eoi_mask;

    assign set_mask = set_valid ? (N'(1) << set_vec) : '0;
    assign ack_mask = ack_take  ? (N'(1) << ack_vec) : '0;
    assign eoi_mask = eoi_take  ? (N'(1) << eoi_vec) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            irr <= '0;
            isr <= '0;
            tmr <= '0;
        end else begin
            irr <= (irr & ~ack_mask) | set_mask;
            isr <= (isr & ~eoi_mask) | ack_mask;
            if (set_valid) tmr[set_vec] <= set_level;
        end
    end
endmodule

// File: rtl/vpc_gate.sv
module vpc_gate
    import vpc_pkg::*;
(
    input  vec_t task_pri,
    input  logic run_any,
    input  vec_t run_top,
    input  logic req_any,
    input  vec_t req_top,
    input  logic enable,
    output vec_t ppr,
    output logic blocked,
    output logic deliver
);
    always_comb begin
        ppr     = ppr_of(task_pri, run_any, run_top);
        blocked = req_any && (ppr != '0) && (cls_of(req_top) <= cls_of(ppr));
        deliver = enable && req_any && !blocked;
    end
endmodule

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl
    import vpc_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_valid,
    input  logic [VEC_W-1:0] set_vec,
    input  logic             set_level,
    input  logic             task_pri_we,
    input  logic [VEC_W-1:0] task_pri_wdata,
    input  logic             spur_cfg_we,
    input  logic [CFG_W-1:0] spur_cfg_wdata,
    input  logic             ack_req,
    input  logic             eoi,
    output logic             irq_out,
    output logic             ack_rsp_valid,
    output logic             ack_rsp_hit,
    output logic [VEC_W-1:0] ack_rsp_vec,
    output logic             eoi_bcast_valid,
    output logic [VEC_W-1:0] eoi_bcast_vec,
    output logic [VEC_W-1:0] proc_pri,
    output logic [CFG_W-1:0] spur_cfg
);
    vec_t             task_pri_q;
    logic [CFG_W-1:0] cfg_q;
    logic [NUM_VEC-1:0] irr, isr, tmr;
    logic             req_any, run_any, blocked, deliver, enable;
    vec_t             req_top, run_top, ppr;
    logic             ack_take, eoi_take;
    ack_rsp_t         rsp_q, rsp_d;
    logic             bc_v_q;
    vec_t             bc_vec_q;

    assign enable = cfg_q[CFG_EN_BIT];

    vpc_prio_scan #(.N(NUM_VEC), .W(WORD_W)) u_req_scan (
        .bits(irr), .found(req_any), .idx(req_top)
    );
    vpc_prio_scan #(.N(NUM_VEC), .W(WORD_W)) u_run_scan (
        .bits(isr), .found(run_any), .idx(run_top)
    );

    vpc_gate u_gate (
        .task_pri(task_pri_q), .run_any(run_any), .run_top(run_top),
        .req_any(req_any), .req_top(req_top), .enable(enable),
        .ppr(ppr), .blocked(blocked), .deliver(deliver)
    );

    always_comb begin
        rsp_d    = '0;
        ack_take = 1'b0;
        if (ack_req) begin
            rsp_d.valid = 1'b1;
            if (enable && req_any) begin
                rsp_d.hit = 1'b1;
                if (blocked) begin
                    rsp_d.vec = cfg_q[VEC_W-1:0];
                end else begin
                    rsp_d.vec = req_top;
                    ack_take  = 1'b1;
                end
            end
        end
    end

    assign eoi_take = eoi && run_any;

    vpc_vec_regs #(.N(NUM_VEC)) u_regs (
        .clk(clk), .rst(rst),
        .set_valid(set_valid), .set_vec(set_vec), .set_level(set_level),
        .ack_take(ack_take), .ack_vec(req_top),
        .eoi_take(eoi_take), .eoi_vec(run_top),
        .irr(irr), .isr(isr), .tmr(tmr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            task_pri_q <= '0;
            cfg_q      <= CFG_RST;
            rsp_q      <= '0;
            bc_v_q     <= 1'b0;
            bc_vec_q   <= '0;
        end else begin
            if (task_pri_we) task_pri_q <= task_pri_wdata;
            if (spur_cfg_we) cfg_q <= spur_cfg_wdata & CFG_KEEP;
            rsp_q    <= rsp_d;
            bc_v_q   <= eoi_take && tmr[run_top] && !cfg_q[CFG_SUP_BIT];
            bc_vec_q <= eoi_take ? run_top : '0;
        end
    end

    assign irq_out         = deliver;
    assign ack_rsp_valid   = rsp_q.valid;
    assign ack_rsp_hit     = rsp_q.hit;
    assign ack_rsp_vec     = rsp_q.vec;
    assign eoi_bcast_valid = bc_v_q;
    assign eoi_bcast_vec   = bc_vec_q;
    assign proc_pri        = ppr;
    assign spur_cfg        = cfg_q;
endmodule

// File: rtl/vpc_chk.sv
module vpc_chk
    import vpc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ack_req,
    input logic             eoi,
    input logic             irq_out,
    input logic             ack_rsp_valid,
    input logic             eoi_bcast_valid,
    input logic [CFG_W-1:0] spur_cfg,
    input logic [VEC_W-1:0] proc_pri,
    input logic [VEC_W-1:0] task_pri_q
);
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> spur_cfg[CFG_EN_BIT]); // R5
    AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        ack_req |=> ack_rsp_valid); // R7
    AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ack_rsp_valid |-> $past(ack_req)); // R7
    AST_BCAST_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        eoi_bcast_valid |-> $past(eoi)); // R9
    AST_BCAST_SUPPRESSED: assert property (@(posedge clk) disable iff (rst)
        eoi_bcast_valid |-> !$past(spur_cfg[CFG_SUP_BIT])); // R10
    AST_CFG_DEAD_BITS: assert property (@(posedge clk) disable iff (rst)
        (spur_cfg & ~CFG_KEEP) == '0); // R11
    AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (rst)
        proc_pri >= task_pri_q); // R4
endmodule

bind vec_prio_ctrl vpc_chk u_chk (
    .clk(clk), .rst(rst), .ack_req(ack_req), .eoi(eoi),
    .irq_out(irq_out), .ack_rsp_valid(ack_rsp_valid),
    .eoi_bcast_valid(eoi_bcast_valid), .spur_cfg(spur_cfg),
    .proc_pri(proc_pri), .task_pri_q(task_pri_q)
);

// File: tb/vec_prio_ctrl_tb.sv
module vec_prio_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        set_valid = 0, set_level = 0, task_pri_we = 0, spur_cfg_we = 0;
    logic        ack_req = 0, eoi = 0;
    logic [7:0]  set_vec = 0, task_pri_wdata = 0;
    logic [15:0] spur_cfg_wdata = 0;
    logic        irq_out, ack_rsp_valid, ack_rsp_hit, eoi_bcast_valid;
    logic [7:0]  ack_rsp_vec, eoi_bcast_vec, proc_pri;
    logic [15:0] spur_cfg;
    int          checks = 0, fails = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    vec_prio_ctrl u_dut (.*);

    localparam logic [3:0] OP_IRQ = 0, OP_PPR = 1, OP_CFGCHK = 2, OP_SE = 3,
        OP_SL = 4, OP_TPR = 5, OP_CFG = 6, OP_ACK = 7, OP_EOI = 8;

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] arg;
        logic        flag;
        logic [7:0]  exp;
        logic [3:0]  req;
    } ent_t;

    localparam int NT = 50;
    localparam ent_t TBL [NT] = '{
        '{OP_IRQ,    16'h0000, 1'b0, 8'h00, 4'd1},  // R1
        '{OP_PPR,    16'h0000, 1'b0, 8'h00, 4'd1},  // R1
        '{OP_CFGCHK, 16'h00FF, 1'b0, 8'h00, 4'd1},  // R1
        '{OP_SE,     16'h0041, 1'b0, 8'h00, 4'd2},
        '{OP_IRQ,    16'h0000, 1'b0, 8'h00, 4'd5},  // R5 disabled
        '{OP_ACK,    16'h0000, 1'b0, 8'h00, 4'd5},  // R5
        '{OP_CFG,    16'hE1E7, 1'b0, 8'h00, 4'd11},
        '{OP_CFGCHK, 16'h01E7, 1'b0, 8'h00, 4'd11}, // R11
        '{OP_IRQ,    16'h0000, 1'b1, 8'h00, 4'd12}, // R12
        '{OP_SL,     16'h0085, 1'b0, 8'h00, 4'd2},
        '{OP_ACK,    16'h0000, 1'b1, 8'h85, 4'd3},  // R3
        '{OP_PPR,    16'h0000, 1'b0, 8'h80, 4'd4},  // R4
        '{OP_IRQ,    16'h0000, 1'b0, 8'h00, 4'd6},  // R6
        '{OP_ACK,    16'h0000, 1'b1, 8'hE7, 4'd6},  // R6 spurious
        '{OP_SE,     16'h0092, 1'b0, 8'h00, 4'd2},
        '{OP_IRQ,    16'h0000, 1'b1, 8'h00, 4'd12}, // R12
        '{OP_ACK,    16'h0000, 1'b1, 8'h92, 4'd3},  // R3
        '{OP_PPR,    16'h0000, 1'b0, 8'h90, 4'd8},  // R8
        '{OP_EOI,    16'h0000, 1'b0, 8'h00, 4'd9},  // R9 edge, no broadcast
        '{OP_PPR,    16'h0000, 1'b0, 8'h80, 4'd9},  // R9
        '{OP_EOI,    16'h0000, 1'b1, 8'h85, 4'd9},  // R9 level
        '{OP_PPR,    16'h0000, 1'b0, 8'h00, 4'd9},  // R9
        '{OP_IRQ,    16'h0000, 1'b1, 8'h00, 4'd12}, // R12
        '{OP_TPR,    16'h0053, 1'b0, 8'h00, 4'd4},
        '{OP_PPR,    16'h0000, 1'b0, 8'h53, 4'd4},  // R4
        '{OP_IRQ,    16'h0000, 1'b0, 8'h00, 4'd6},  // R6
        '{OP_ACK,    16'h0000, 1'b1, 8'hE7, 4'd6},  // R6
        '{OP_TPR,    16'h0030, 1'b0, 8'h00, 4'd4},
        '{OP_IRQ,    16'h0000, 1'b1, 8'h00, 4'd6},  // R6 unblocked
        '{OP_ACK,    16'h0000, 1'b1, 8'h41, 4'd8},  // R8
        '{OP_PPR,    16'h0000, 1'b0, 8'h40, 4'd4},  // R4
        '{OP_IRQ,    16'h0000, 1'b0, 8'h00, 4'd8},  // R8
        '{OP_ACK,    16'h0000, 1'b0, 8'h00, 4'd7},  // R7
        '{OP_EOI,    16'h0000, 1'b0, 8'h00, 4'd9},  // R9
        '{OP_EOI,    16'h0000, 1'b0, 8'h00, 4'd9},  // R9 empty
        '{OP_PPR,    16'h0000, 1'b0, 8'h30, 4'd9},  // R9
        '{OP_CFG,    16'hF1FF, 1'b0, 8'h00, 4'd11},
        '{OP_CFGCHK, 16'h11FF, 1'b0, 8'h00, 4'd11}, // R11
        '{OP_SL,     16'h0060, 1'b0, 8'h00, 4'd2},
        '{OP_ACK,    16'h0000, 1'b1, 8'h60, 4'd10}, // R10
        '{OP_EOI,    16'h0000, 1'b0, 8'h00, 4'd10}, // R10
        '{OP_CFG,    16'h01FF, 1'b0, 8'h00, 4'd11},
        '{OP_SL,     16'h0070, 1'b0, 8'h00, 4'd2},
        '{OP_SE,     16'h0070, 1'b0, 8'h00, 4'd2},
        '{OP_ACK,    16'h0000, 1'b1, 8'h70, 4'd2},  // R2
        '{OP_EOI,    16'h0000, 1'b0, 8'h00, 4'd2},  // R2 edge cleared mark
        '{OP_SL,     16'h0071, 1'b0, 8'h00, 4'd2},
        '{OP_ACK,    16'h0000, 1'b1, 8'h71, 4'd2},  // R2
        '{OP_EOI,    16'h0000, 1'b1, 8'h71, 4'd2},  // R2 level broadcast
        '{OP_IRQ,    16'h0000, 1'b0, 8'h00, 4'd7}   // R7
    };

    task automatic chk(input int rq, input string what, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d %s: got %h expected %h", rq, what, got, exp);
        end
    endtask

    task automatic run_op(input ent_t e);
        if (e.op == OP_IRQ) chk(e.req, "irq_out", 16'(irq_out), 16'(e.flag));
        else if (e.op == OP_PPR) chk(e.req, "proc_pri", 16'(proc_pri), 16'(e.exp));
        else if (e.op == OP_CFGCHK) chk(e.req, "spur_cfg", spur_cfg, e.arg);
        else begin
            case (e.op)
                OP_SE:  begin set_valid = 1; set_vec = e.arg[7:0]; set_level = 0; end
                OP_SL:  begin set_valid = 1; set_vec = e.arg[7:0]; set_level = 1; end
                OP_TPR: begin task_pri_we = 1; task_pri_wdata = e.arg[7:0]; end
                OP_CFG: begin spur_cfg_we = 1; spur_cfg_wdata = e.arg; end
                OP_ACK: ack_req = 1;
                OP_EOI: eoi = 1;
                default: ;
            endcase
            @(negedge clk);
            set_valid = 0; task_pri_we = 0; spur_cfg_we = 0; ack_req = 0; eoi = 0;
            if (e.op == OP_ACK) begin
                chk(e.req, "ack valid", 16'(ack_rsp_valid), 16'h1);
                chk(e.req, "ack hit", 16'(ack_rsp_hit), 16'(e.flag));
                if (e.flag) chk(e.req, "ack vec", 16'(ack_rsp_vec), 16'(e.exp));
            end else if (e.op == OP_EOI) begin
                chk(e.req, "bcast valid", 16'(eoi_bcast_valid), 16'(e.flag));
                if (e.flag) chk(e.req, "bcast vec", 16'(eoi_bcast_vec), 16'(e.exp));
            end
        end
    endtask

    task automatic op(input logic [3:0] o, input logic [15:0] a, input logic f,
                      input logic [7:0] x, input logic [3:0] r);
        ent_t e;
        e = '{o, a, f, x, r};
        run_op(e);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        for (int i = 0; i < NT; i++) run_op(TBL[i]);

        // R3: word boundary, 0x20 outranks 0x1F
        op(OP_TPR, 16'h0000, 0, 8'h00, 4'd3);
        op(OP_SE,  16'h001F, 0, 8'h00, 4'd3);
        op(OP_SE,  16'h0020, 0, 8'h00, 4'd3);
        op(OP_ACK, 16'h0000, 1, 8'h20, 4'd3);
        op(OP_EOI, 16'h0000, 0, 8'h00, 4'd3);
        op(OP_ACK, 16'h0000, 1, 8'h1F, 4'd3);
        op(OP_EOI, 16'h0000, 0, 8'h00, 4'd3);

        // R1: reset in the middle of activity
        op(OP_SL,  16'h00C0, 0, 8'h00, 4'd1);
        op(OP_IRQ, 16'h0000, 1, 8'h00, 4'd1);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        op(OP_IRQ,    16'h0000, 0, 8'h00, 4'd1);
        op(OP_PPR,    16'h0000, 0, 8'h00, 4'd1);
        op(OP_CFGCHK, 16'h00FF, 0, 8'h00, 4'd1);
        op(OP_CFG,    16'h01FF, 0, 8'h00, 4'd1);
        op(OP_ACK,    16'h0000, 0, 8'h00, 4'd1); // R1 request map cleared

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule